// File: doc/BRIEF.md
# Interrupt Status Aggregator With Selective Read-Clear

This block gathers interrupt causes into one 32-bit status word and raises a single interrupt line. Single-cycle event pulses become sticky flags. Level summaries from second-level status logic pass straight into the word. A transmit completion index is mirrored into the upper bits.

Software reaches four word registers over a plain register bus:

| Address | Register | Access |
|---|---|---|
| 0 | Main status | Read only. A read clears every sticky flag. |
| 1 | Mask | Read/write |
| 2 | Alias-clear select | Read/write |
| 3 | Status alias | Read only. A read returns the main status word but clears only the flags chosen in the alias-clear select. |

A read returns its data on `reg_rd_data` one cycle after `reg_rd_en`. The bus has no handshake and no back-pressure: a read or a write always completes in the cycle it is presented. A read and a write may share a cycle. In that case the read returns the register contents from before the write.

Status word layout:

| Bits | Content |
|---|---|
| [10:0] | Sticky event flags |
| [11] | Reserved, always 0 |
| [12] | Summary, equal to the current state of `irq_o` |
| [18:13] | Second-level level inputs |
| [31:19] | Transmit completion index |

Top module: `irq_alias_status`

## Requirements
- R1: After reset the following hold: every sticky flag is 0, the mask reads 0x7FFFF at address 1, the alias-clear select reads 0 at address 2, and `irq_o`, `err_o` and `reg_rd_data` are 0.
- R2: A 1 on `ev_i[k]` (k from 0 to 10) sets status bit k at the next clock edge. The bit then stays set until a clearing read.
- R3: A read at address 0 returns the status word as it stood in the read cycle, on `reg_rd_data` one cycle later. The read clears all sticky flags. An event arriving in the same cycle as the read leaves its flag set.
- R4: A read at address 3 returns the same word as address 0. It clears only the sticky flags k for which bit k of the alias-clear select is 1 (select bits [10:0], written at address 2). An event in the same cycle still wins.
- R5: Status bits [18:13] always equal `lvl_i[5:0]` at the read cycle. No read ever changes them.
- R6: Status bits [31:19] equal `txc_idx_i` at the read cycle. Bit 11 always reads 0.
- R7: The mask (address 1, bits [18:0]) suppresses any source bit whose mask bit is 1. `irq_o` is a register loaded with the OR of status & ~mask over bits [10:0] and [18:13]. An unmasked event pulse therefore raises `irq_o` two edges after the pulse, and a level input raises it one edge after it changes.
- R8: Status bit 12 reads the value of `irq_o` in the read cycle.
- R9: `err_o` is a register loaded with the OR of status bits 3, 6, 10 and 18:13, without regard to the mask.
- R10: Writes to addresses 0 and 3 change nothing. `reg_rd_data` holds its value in cycles without a read. The alias-clear select reads back in bits [10:0] with the upper bits 0; the mask reads back in bits [18:0] with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 11 | Event pulses, one per sticky flag |
| lvl_i | input | 6 | Second-level summary levels |
| txc_idx_i | input | 13 | Transmit completion index |
| reg_addr | input | 2 | Register word address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 19 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt line |
| err_o | output | 1 | Error summary |

## Verification
Read data is due one edge after the strobe. A sticky flag is due one edge after its pulse. `irq_o` and `err_o` are due one edge after the status word changes, which is two edges after an event pulse and one edge after a level change. The bench drives every input on the falling edge and advances a cycle model at each rising edge using the values just driven. It then compares all three outputs against that model at the next falling edge, so every check samples exactly where the register count places the result. The directed cases additionally check literal expected words at those same sample points.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W   = 32;
  localparam int EV_W     = 11;
  localparam int LVL_W    = 6;
  localparam int LVL_LSB  = 13;
  localparam int SUM_BIT  = 12;
  localparam int IDX_W    = 13;
  localparam int IDX_LSB  = LVL_LSB + LVL_W;
  localparam int MASK_W   = IDX_LSB;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_ACLR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_ALIAS = 2'd3;

  // error class: two tag errors, length mismatch, all level summaries
  localparam logic [STAT_W-1:0] ERR_SEL = 32'h0007_E448;
  // bits that feed the interrupt line (summary and reserved excluded)
  localparam logic [MASK_W-1:0] IRQ_SRC = 19'h7_E7FF;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_i[k])   flag_q <= 1'b1;   // a new event outranks a clear
      else if (clr_i[k])   flag_q <= 1'b0;
    end
    assign q_o[k] = flag_q;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int MW = MASK_W,
  parameter int CW = EV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MW-1:0]     wr_data,
  output logic [MW-1:0]     mask_o,
  output logic [CW-1:0]     aclr_o
);
  logic [MW-1:0] mask_q;
  logic [CW-1:0] aclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      aclr_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADR_MASK: mask_q <= wr_data;
        ADR_ACLR: aclr_q <= wr_data[CW-1:0];
        default:  ;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign aclr_o = aclr_q;
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [EV_W-1:0]   aclr_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic [EV_W-1:0]   clr_o
);
  logic [STAT_W-1:0] sel;
  logic [STAT_W-1:0] rd_q;

  always_comb begin
    sel   = '0;
    clr_o = '0;
    case (addr)
      ADR_STAT: begin
        sel = stat_i;
        if (rd_en) clr_o = '1;
      end
      ADR_ALIAS: begin
        sel = stat_i;
        if (rd_en) clr_o = aclr_i;
      end
      ADR_MASK: sel[MASK_W-1:0] = mask_i;
      default:  sel[EV_W-1:0]   = aclr_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= sel;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_alias_status.sv
module irq_alias_status
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_W-1:0]   ev_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [IDX_W-1:0]  txc_idx_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [MASK_W-1:0] reg_wr_data,
  input  logic              reg_rd_en,
  output logic [STAT_W-1:0] reg_rd_data,
  output logic              irq_o,
  output logic              err_o
);
  logic [EV_W-1:0]   sticky;
  logic [EV_W-1:0]   clr_req;
  logic [MASK_W-1:0] mask;
  logic [EV_W-1:0]   aclr;
  logic [STAT_W-1:0] stat_word;
  logic              irq_q;
  logic              err_q;

  irq_sticky_bank #(.W(EV_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_i),
    .clr_i (clr_req),
    .q_o   (sticky)
  );

  irq_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wr_data),
    .mask_o  (mask),
    .aclr_o  (aclr)
  );

  always_comb begin
    stat_word = '0;
    stat_word[EV_W-1:0]               = sticky;
    stat_word[SUM_BIT]                = irq_q;
    stat_word[LVL_LSB +: LVL_W]       = lvl_i;
    stat_word[IDX_LSB +: IDX_W]       = txc_idx_i;
  end

  irq_read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .stat_i    (stat_word),
    .mask_i    (mask),
    .aclr_i    (aclr),
    .rd_data_o (reg_rd_data),
    .clr_o     (clr_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= |(stat_word[MASK_W-1:0] & ~mask & IRQ_SRC);
      err_q <= |(stat_word & ERR_SEL);
    end
  end

  assign irq_o = irq_q;
  assign err_o = err_q;
endmodule

// File: rtl/irq_alias_status_chk.sv
module irq_alias_status_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [EV_W-1:0]   ev_i,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [EV_W-1:0]   sticky,
  input logic [EV_W-1:0]   aclr,
  input logic [MASK_W-1:0] mask,
  input logic [STAT_W-1:0] reg_rd_data,
  input logic              irq_o
);
  // R2: a pulse leaves its flag set on the next edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((sticky & $past(ev_i)) == $past(ev_i)));

  // R3: a main read leaves only the flags of simultaneous events
  a_r3_main_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADR_STAT) |=> (sticky == $past(ev_i)));

  // R4: an alias read never keeps a selected flag unless it was re-raised
  a_r4_alias_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADR_ALIAS) |=>
      ((sticky & $past(aclr) & ~$past(ev_i)) == '0));

  // R4: unselected flags survive an alias read
  a_r4_alias_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADR_ALIAS) |=>
      ((sticky & ~$past(aclr)) == ($past(sticky) & ~$past(aclr)) | ($past(ev_i) & ~$past(aclr))));

  // R7: a fully set mask keeps the line low
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |=> !irq_o);

  // R10: read data holds without a read
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rd_data));
endmodule

bind irq_alias_status irq_alias_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_i        (ev_i),
  .reg_rd_en   (reg_rd_en),
  .reg_addr    (reg_addr),
  .sticky      (sticky),
  .aclr        (aclr),
  .mask        (mask),
  .reg_rd_data (reg_rd_data),
  .irq_o       (irq_o)
);

// File: tb/test_irq_alias_status.sv
`timescale 1ns/1ps
module test_irq_alias_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] ev = '0;
  logic [5:0]  lvl = '0;
  logic [12:0] idx = '0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [18:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq, err;

  int n_chk = 0;
  int n_bad = 0;

  irq_alias_status i_irq_alias_status (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .lvl_i(lvl), .txc_idx_i(idx),
    .reg_addr(addr), .reg_wr_en(wr_en), .reg_wr_data(wdata),
    .reg_rd_en(rd_en), .reg_rd_data(rd_data), .irq_o(irq), .err_o(err)
  );

  always #2 clk = ~clk;

  // cycle model
  logic [10:0] m_st;
  logic [18:0] m_mask;
  logic [10:0] m_aclr;
  logic        m_irq, m_err;
  logic [31:0] m_rd;
  string       m_tag;

  function automatic logic [31:0] full_word(logic [10:0] st, logic irq_v,
                                            logic [5:0] l, logic [12:0] ix);
    return {ix, l, irq_v, 1'b0, st};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = '0; m_mask = '1; m_aclr = '0; m_irq = 0; m_err = 0; m_rd = '0;
    m_tag = "R1";
  endtask

  task automatic model_edge();
    logic [31:0] f;
    logic [10:0] clr;
    f = full_word(m_st, m_irq, lvl, idx);
    clr = '0;
    if (rd_en) begin
      case (addr)
        2'd0: begin m_rd = f; clr = '1; m_tag = "R3 R5 R6 R8"; end
        2'd3: begin m_rd = f; clr = m_aclr; m_tag = "R4 R5 R6 R8"; end
        2'd1: begin m_rd = {13'd0, m_mask}; m_tag = "R10 mask"; end
        default: begin m_rd = {21'd0, m_aclr}; m_tag = "R10 aclr"; end
      endcase
    end
    m_irq = |(f[18:0] & ~m_mask & 19'h7E7FF);
    m_err = |(f & 32'h0007_E448);
    m_st  = (m_st & ~clr) | ev;
    if (wr_en && addr == 2'd1) m_mask = wdata;
    if (wr_en && addr == 2'd2) m_aclr = wdata[10:0];
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R7 irq", {31'd0, irq}, {31'd0, m_irq});
    check("R9 err", {31'd0, err}, {31'd0, m_err});
    check(m_tag, rd_data, m_rd);
  endtask

  task automatic idle();
    ev = '0; wr_en = 0; rd_en = 0;
  endtask

  task automatic do_read(logic [1:0] a);
    addr = a; rd_en = 1; tick(); idle();
  endtask

  task automatic do_write(logic [1:0] a, logic [18:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); idle();
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    @(negedge clk); @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rst_n = 1;
    @(negedge clk);
    do_read(2'd1);  check("R1 mask reset", rd_data, 32'h0007_FFFF);
    do_read(2'd2);  check("R1 aclr reset", rd_data, 32'd0);
    do_read(2'd0);  check("R1 status reset", rd_data, 32'd0);

    // unmask all, event on bit 1 then watch irq two edges later
    do_write(2'd1, 19'd0);
    ev = 11'h002; tick(); idle();
    check("R2 not yet irq", {31'd0, irq}, 32'd0);
    tick();
    check("R7 irq after two edges", {31'd0, irq}, 32'd1);
    do_read(2'd0);
    check("R3 R8 read word", rd_data, 32'h0000_1002);
    tick();
    check("R3 cleared irq drops", {31'd0, irq}, 32'd0);

    // event coincident with clearing read survives
    ev = 11'h010; tick(); idle();
    addr = 2'd0; rd_en = 1; ev = 11'h001; tick(); idle();
    check("R3 read before clear", rd_data, 32'h0000_0010);
    do_read(2'd0);
    check("R3 same cycle event kept", rd_data[10:0], 32'h1);

    // alias read: select bits 0 and 2 only
    do_write(2'd2, 19'h0005);
    do_read(2'd0);
    ev = 11'h00F; tick(); idle();
    do_read(2'd3);
    check("R4 alias word", rd_data[10:0], 32'h00F);
    do_read(2'd0);
    check("R4 unselected kept", rd_data[10:0], 32'h00A);

    // writes to read-only addresses ignored
    do_write(2'd0, 19'h7FFFF);
    do_write(2'd3, 19'h7FFFF);
    do_read(2'd1); check("R10 mask untouched", rd_data, 32'd0);
    do_read(2'd2); check("R10 aclr untouched", rd_data, 32'h5);

    // level and index mirrors, unaffected by read
    lvl = 6'h2A; idx = 13'h1ABC; tick();
    check("R9 level raises err", {31'd0, err}, 32'd1);
    do_read(2'd0);
    check("R5 level bits", {26'd0, rd_data[18:13]}, 32'h2A);
    check("R6 index bits", {19'd0, rd_data[31:19]}, 32'h1ABC);
    check("R6 reserved bit", {31'd0, rd_data[11]}, 32'd0);
    do_read(2'd0);
    check("R5 level survives read", {26'd0, rd_data[18:13]}, 32'h2A);

    // masked: error still reported, irq quiet
    do_write(2'd1, 19'h7FFFF);
    lvl = 6'h01; tick(); tick();
    check("R7 masked no irq", {31'd0, irq}, 32'd0);
    check("R9 err ignores mask", {31'd0, err}, 32'd1);
    lvl = 6'h00;

    // random phase
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ev = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : 11'd0;
      if ($urandom_range(0, 15) == 0) lvl = 6'($urandom());
      if ($urandom_range(0, 7) == 0)  idx = 13'($urandom());
      addr = 2'($urandom());
      rd_en = (r < 30);
      wr_en = (r >= 80);
      wdata = 19'($urandom());
      tick();
      idle();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule